// File: doc/BRIEF.md
# Multiplexed External RAM Bus Controller

This block gives a small 8-bit controller core a parallel path to up to 256 bytes of external RAM. It watches the 14-bit instruction stream. Within the move-literal opcode group it recognises two extra operations: an external read and an external write. The low byte of the instruction is the RAM address.

Each accepted access runs a fixed four-phase bus cycle (T1 to T4) on an 8-bit address/data bus that is shared between address and data. During the access the bus borrows the port-B pins. Port-A pins 3, 2 and 1 carry the address latch enable, the read/write strobe and the active-low chip select. At all other times every pin follows the core's general-purpose output and output-enable values. A read loads the fetched byte into the core's working register through a one-cycle load pulse in T4. A write drives the working-register value that was sampled when the instruction was accepted.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: An access starts only when `instr_valid_i` is high while idle and `instr_i[13:10]`=1100 with `instr_i[9:8]`=01 (read) or 10 (write). The codes 00 (move literal), 11 (reserved) and any other group leave `busy_o` low and all pins in port mode.
- R2: In T1 all eight port-B pins are driven (`pb_oe_o`=FF) with `instr_i[7:0]` as the address.
- R3: `pa_o[3]` (latch enable) is high in T1 only. Port-A pin 3 has `pa_oe_o[3]`=1 throughout T1 to T4.
- R4: `pa_o[2]` is 1 for a read and 0 for a write, held constant from T1 to T4.
- R5: `pa_o[1]` (chip select) is 0 from T1 to T4. Port-A pins 1 to 3 have output enable forced on during an access.
- R6: Port-A pin 0 always follows `pa_out_i[0]`/`pa_oe_i[0]`. Pins 1 to 3 follow the port inputs whenever no access is in progress.
- R7: A write drives the `w_i` value sampled at acceptance on port B in T2 and T3, and releases the bus (`pb_oe_o`=00) in T4.
- R8: A read releases the bus from T2 to T4 and captures `pb_pad_i` at the end of T3. In T4 it raises `w_load_o` for one cycle, with the captured byte on `w_data_o`.
- R9: Every access lasts exactly four cycles. `busy_o` is high in T1 to T4 and `done_o` is high in T4 only. An instruction presented while busy is not accepted.
- R10: When idle, `pb_o`/`pb_oe_o` equal `pb_out_i`/`pb_oe_i`. After reset the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one bus phase per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction on `instr_i` is being issued |
| instr_i | input | 14 | Instruction word |
| w_i | input | 8 | Working-register value (write data) |
| busy_o | output | 1 | External access in progress |
| done_o | output | 1 | Final phase of an access |
| w_load_o | output | 1 | Load `w_data_o` into working register |
| w_data_o | output | 8 | Byte read from external RAM |
| pa_out_i | input | 4 | Core's port-A output values |
| pa_oe_i | input | 4 | Core's port-A output enables |
| pa_o | output | 4 | Port-A pin output values |
| pa_oe_o | output | 4 | Port-A pin output enables |
| pb_out_i | input | 8 | Core's port-B output values |
| pb_oe_i | input | 8 | Core's port-B output enables |
| pb_o | output | 8 | Port-B pin output values (AD bus) |
| pb_oe_o | output | 8 | Port-B pin output enables |
| pb_pad_i | input | 8 | Port-B pin input values |

## Verification
The bench builds the block with its default parameters: a 14-bit instruction, an 8-bit bus, and strobes on port-A pins 3, 2 and 1. With these values the whole 256-byte address space can be reached, so accesses to address 00 and FF are exercised against a RAM model that has the bus timing of the pins. A write followed by a read of the same address shows the round trip through that model. A valid held high across an access exercises the busy-drop rule.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  typedef enum logic [1:0] {
    OP_LIT = 2'b00,
    OP_XRD = 2'b01,
    OP_XWR = 2'b10,
    OP_RSV = 2'b11
  } xop_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_T1, PH_T2, PH_T3, PH_T4
  } phase_e;

  localparam logic [3:0] GRP_LIT = 4'b1100;
endpackage

// File: rtl/xmem_decode.sv
module xmem_decode
  import xmem_pkg::*;
#(
  parameter int INSTR_W = 14,
  parameter int ADDR_W  = 8
) (
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic               xrd_o,
  output logic               xwr_o,
  output logic [ADDR_W-1:0]  addr_o
);
  logic [3:0] grp;
  xop_e       sub;
  logic       in_grp;

  assign grp    = instr_i[INSTR_W-1 -: 4];
  assign sub    = xop_e'(instr_i[INSTR_W-5 -: 2]);
  assign in_grp = valid_i && (grp == GRP_LIT);
  assign xrd_o  = in_grp && (sub == OP_XRD);
  assign xwr_o  = in_grp && (sub == OP_XWR);
  assign addr_o = instr_i[ADDR_W-1:0];
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xrd_i,
  input  logic              xwr_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] bus_in_i,
  output phase_e            phase_o,
  output logic              is_read_o,
  output logic [DATA_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);
  phase_e phase_q, phase_d;
  logic   start;

  assign start = (phase_q == PH_IDLE) && (xrd_i || xwr_i);

  always_comb begin
    unique case (phase_q)
      PH_IDLE: phase_d = start ? PH_T1 : PH_IDLE;
      PH_T1:   phase_d = PH_T2;
      PH_T2:   phase_d = PH_T3;
      PH_T3:   phase_d = PH_T4;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      is_read_o <= 1'b0;
      addr_o    <= '0;
      wdata_o   <= '0;
      rdata_o   <= '0;
    end else begin
      phase_q <= phase_d;
      if (start) begin
        is_read_o <= xrd_i;
        addr_o    <= addr_i;
        wdata_o   <= wdata_i;
      end
      // capture at the close of T3
      if (phase_q == PH_T3 && is_read_o) rdata_o <= bus_in_i;
    end
  end

  assign phase_o = phase_q;

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_T4) |=> (phase_q != PH_T4));
  assert_no_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE && phase_q != PH_T4) |=> (phase_q != PH_T1));
endmodule

// File: rtl/xmem_pin_mux.sv
module xmem_pin_mux #(
  parameter int PA_W    = 4,
  parameter int DATA_W  = 8,
  parameter int ALE_PIN = 3,
  parameter int RW_PIN  = 2,
  parameter int CS_PIN  = 1
) (
  input  logic              active_i,
  input  logic              ale_i,
  input  logic              rw_i,
  input  logic              cs_n_i,
  input  logic              bus_oe_i,
  input  logic [DATA_W-1:0] bus_val_i,
  input  logic [PA_W-1:0]   pa_out_i,
  input  logic [PA_W-1:0]   pa_oe_i,
  input  logic [DATA_W-1:0] pb_out_i,
  input  logic [DATA_W-1:0] pb_oe_i,
  output logic [PA_W-1:0]   pa_o,
  output logic [PA_W-1:0]   pa_oe_o,
  output logic [DATA_W-1:0] pb_o,
  output logic [DATA_W-1:0] pb_oe_o
);
  for (genvar i = 0; i < PA_W; i++) begin : g_pa
    if (i == ALE_PIN) begin : g_ale
      assign pa_o[i]    = active_i ? ale_i : pa_out_i[i];
      assign pa_oe_o[i] = active_i | pa_oe_i[i];
    end else if (i == RW_PIN) begin : g_rw
      assign pa_o[i]    = active_i ? rw_i : pa_out_i[i];
      assign pa_oe_o[i] = active_i | pa_oe_i[i];
    end else if (i == CS_PIN) begin : g_cs
      assign pa_o[i]    = active_i ? cs_n_i : pa_out_i[i];
      assign pa_oe_o[i] = active_i | pa_oe_i[i];
    end else begin : g_gpio
      assign pa_o[i]    = pa_out_i[i];
      assign pa_oe_o[i] = pa_oe_i[i];
    end
  end

  assign pb_o    = active_i ? bus_val_i : pb_out_i;
  assign pb_oe_o = active_i ? {DATA_W{bus_oe_i}} : pb_oe_i;
endmodule

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl
  import xmem_pkg::*;
#(
  parameter int INSTR_W = 14,
  parameter int DATA_W  = 8,
  parameter int PA_W    = 4,
  parameter int ALE_PIN = 3,
  parameter int RW_PIN  = 2,
  parameter int CS_PIN  = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               instr_valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  w_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               w_load_o,
  output logic [DATA_W-1:0]  w_data_o,
  input  logic [PA_W-1:0]    pa_out_i,
  input  logic [PA_W-1:0]    pa_oe_i,
  output logic [PA_W-1:0]    pa_o,
  output logic [PA_W-1:0]    pa_oe_o,
  input  logic [DATA_W-1:0]  pb_out_i,
  input  logic [DATA_W-1:0]  pb_oe_i,
  output logic [DATA_W-1:0]  pb_o,
  output logic [DATA_W-1:0]  pb_oe_o,
  input  logic [DATA_W-1:0]  pb_pad_i
);
  logic              xrd, xwr, is_read, active, ale, bus_oe;
  logic [DATA_W-1:0] dec_addr, addr_q, wdata_q, rdata_q, bus_val;
  phase_e            phase;

  xmem_decode #(.INSTR_W(INSTR_W), .ADDR_W(DATA_W)) u_dec (
    .valid_i (instr_valid_i),
    .instr_i (instr_i),
    .xrd_o   (xrd),
    .xwr_o   (xwr),
    .addr_o  (dec_addr)
  );

  xmem_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .xrd_i     (xrd),
    .xwr_i     (xwr),
    .addr_i    (dec_addr),
    .wdata_i   (w_i),
    .bus_in_i  (pb_pad_i),
    .phase_o   (phase),
    .is_read_o (is_read),
    .addr_o    (addr_q),
    .wdata_o   (wdata_q),
    .rdata_o   (rdata_q)
  );

  assign active  = (phase != PH_IDLE);
  assign ale     = (phase == PH_T1);
  assign bus_oe  = ale || (!is_read && (phase == PH_T2 || phase == PH_T3));
  assign bus_val = ale ? addr_q : wdata_q;

  xmem_pin_mux #(
    .PA_W(PA_W), .DATA_W(DATA_W),
    .ALE_PIN(ALE_PIN), .RW_PIN(RW_PIN), .CS_PIN(CS_PIN)
  ) u_mux (
    .active_i  (active),
    .ale_i     (ale),
    .rw_i      (is_read),
    .cs_n_i    (!active),
    .bus_oe_i  (bus_oe),
    .bus_val_i (bus_val),
    .pa_out_i  (pa_out_i),
    .pa_oe_i   (pa_oe_i),
    .pb_out_i  (pb_out_i),
    .pb_oe_i   (pb_oe_i),
    .pa_o      (pa_o),
    .pa_oe_o   (pa_oe_o),
    .pb_o      (pb_o),
    .pb_oe_o   (pb_oe_o)
  );

  assign busy_o   = active;
  assign done_o   = (phase == PH_T4);
  assign w_load_o = done_o && is_read;
  assign w_data_o = rdata_q;

  assert_reserved_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && instr_valid_i && instr_i[INSTR_W-1 -: 4] == GRP_LIT &&
     instr_i[INSTR_W-5 -: 2] == 2'b11) |=> !busy_o);
  assert_ale_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pa_o[ALE_PIN] && busy_o |-> (&pb_oe_o));
  assert_ale_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && pa_o[ALE_PIN]) |=> !pa_o[ALE_PIN]);
  assert_rw_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !pa_o[ALE_PIN]) |-> $stable(pa_o[RW_PIN]));
  assert_cs_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!pa_o[CS_PIN] && pa_oe_o[CS_PIN]));
  assert_read_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && pa_o[RW_PIN] && !pa_o[ALE_PIN]) |-> (pb_oe_o == '0));
endmodule

// File: tb/xmem_bus_ctrl_test.sv
module xmem_bus_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        instr_valid = 1'b0;
  logic [13:0] instr = '0;
  logic [7:0]  w = '0;
  logic        busy, done, w_load;
  logic [7:0]  w_data;
  logic [3:0]  pa_out = '0, pa_oe = 4'b0001, pa_o, pa_oe_o;
  logic [7:0]  pb_out = '0, pb_oe = '0, pb_o, pb_oe_o, pb_pad, pb_ext = 8'h3C;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  xmem_bus_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .instr_valid_i(instr_valid), .instr_i(instr),
    .w_i(w), .busy_o(busy), .done_o(done), .w_load_o(w_load), .w_data_o(w_data),
    .pa_out_i(pa_out), .pa_oe_i(pa_oe), .pa_o(pa_o), .pa_oe_o(pa_oe_o),
    .pb_out_i(pb_out), .pb_oe_i(pb_oe), .pb_o(pb_o), .pb_oe_o(pb_oe_o),
    .pb_pad_i(pb_pad)
  );

  // external RAM with latch, pin-level only
  logic [7:0] ram [256];
  logic [7:0] ram_lat = '0;
  logic cs_act, rd_pin, ale_pin;
  assign ale_pin = pa_oe_o[3] & pa_o[3];
  assign rd_pin  = pa_o[2];
  assign cs_act  = pa_oe_o[1] & ~pa_o[1];
  assign pb_pad  = (cs_act && rd_pin && !ale_pin) ? ram[ram_lat] : pb_ext;
  always @(posedge clk) begin
    if (ale_pin) ram_lat <= pb_o;
    if (cs_act && !rd_pin && !ale_pin && pb_oe_o == 8'hFF) ram[ram_lat] <= pb_o;
  end

  // reference model
  logic [7:0] exp_mem [256];
  int         ph = 0;
  bit         m_rd = 0;
  logic [7:0] m_addr = '0, m_wd = '0;
  bit         s_rst = 0, s_valid = 0;
  logic [13:0] s_instr = '0;
  logic [7:0]  s_w = '0;

  initial begin
    for (int i = 0; i < 256; i++) begin
      ram[i]     = 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!s_rst) ph = 0;
    else if (ph == 0) begin
      if (s_valid && s_instr[13:10] == 4'b1100 &&
          (s_instr[9:8] == 2'b01 || s_instr[9:8] == 2'b10)) begin
        ph = 1; m_rd = (s_instr[9:8] == 2'b01);
        m_addr = s_instr[7:0]; m_wd = s_w;
        if (!m_rd) exp_mem[m_addr] = m_wd;
      end
    end else if (ph == 4) ph = 0;
    else ph = ph + 1;
  end

  always @(negedge clk) begin
    logic [7:0] e_oe, e_o;
    s_rst = rst_ni; s_valid = instr_valid; s_instr = instr; s_w = w;
    chk(busy == (ph != 0), ph == 0 ? "R1/R10 busy idle" : "R9 busy", 16'(busy), 16'(ph != 0));
    chk(done == (ph == 4), "R9 done", 16'(done), 16'(ph == 4));
    chk({pa_o[0], pa_oe_o[0]} == {pa_out[0], pa_oe[0]}, "R6 pin0", 16'({pa_o[0], pa_oe_o[0]}),
        16'({pa_out[0], pa_oe[0]}));
    if (ph == 0) begin
      chk({pa_o[3:1], pa_oe_o[3:1]} == {pa_out[3:1], pa_oe[3:1]}, "R6 idle strobes",
          16'({pa_o[3:1], pa_oe_o[3:1]}), 16'({pa_out[3:1], pa_oe[3:1]}));
      chk({pb_o, pb_oe_o} == {pb_out, pb_oe}, "R10 port B idle", {pb_o, pb_oe_o}, {pb_out, pb_oe});
      chk(w_load == 1'b0, "R8 no load idle", 16'(w_load), 16'd0);
    end else begin
      chk(pa_o[3] == (ph == 1) && pa_oe_o[3], "R3 ale", 16'({pa_o[3], pa_oe_o[3]}), 16'({ph == 1, 1'b1}));
      chk(pa_o[2] == m_rd && pa_oe_o[2], "R4 rw", 16'({pa_o[2], pa_oe_o[2]}), 16'({m_rd, 1'b1}));
      chk(!pa_o[1] && pa_oe_o[1], "R5 cs", 16'({pa_o[1], pa_oe_o[1]}), 16'h0001);
      if (ph == 1) begin e_oe = 8'hFF; e_o = m_addr; end
      else if (!m_rd && ph < 4) begin e_oe = 8'hFF; e_o = m_wd; end
      else begin e_oe = 8'h00; e_o = pb_o; end
      chk(pb_oe_o == e_oe, ph == 1 ? "R2 addr oe" : (m_rd ? "R8 release" : "R7 write oe"),
          16'(pb_oe_o), 16'(e_oe));
      chk(pb_o == e_o, ph == 1 ? "R2 addr" : "R7 write data", 16'(pb_o), 16'(e_o));
      chk(w_load == (ph == 4 && m_rd), "R8 load pulse", 16'(w_load), 16'(ph == 4 && m_rd));
      if (ph == 4 && m_rd)
        chk(w_data == exp_mem[m_addr], "R8 read data", 16'(w_data), 16'(exp_mem[m_addr]));
    end
  end

  task automatic step();
    @(posedge clk); #1;
    pa_out = pa_out + 4'd5;
    pb_out = pb_out ^ 8'hA5 + 8'd1;
    pb_oe  = ~pb_oe;
    pb_ext = pb_ext + 8'd17;
  endtask

  task automatic issue(input logic [13:0] ins, input logic [7:0] wv, input int hold);
    instr = ins; w = wv; instr_valid = 1'b1;
    for (int i = 0; i < hold; i++) step();
    instr_valid = 1'b0;
    for (int i = 0; i < 6; i++) step();
  endtask

  initial begin
    repeat (3) step();
    rst_ni = 1'b1;
    repeat (3) step();
    issue({4'b1100, 2'b10, 8'h12}, 8'h5A, 1);  // R7 write
    issue({4'b1100, 2'b01, 8'h12}, 8'h00, 1);  // R8 read back
    issue({4'b1100, 2'b01, 8'hFF}, 8'h00, 1);  // R8 top address
    issue({4'b1100, 2'b00, 8'h44}, 8'h11, 1);  // R1 move literal
    issue({4'b1100, 2'b11, 8'h44}, 8'h11, 1);  // R1 reserved
    issue({4'b0100, 2'b01, 8'h44}, 8'h11, 1);  // R1 other group
    issue({4'b1100, 2'b10, 8'h00}, 8'hC3, 6);  // R9 held valid while busy
    issue({4'b1100, 2'b01, 8'h00}, 8'h00, 1);  // R2 address 00
    issue({4'b1100, 2'b10, 8'hFF}, 8'h81, 1);
    issue({4'b1100, 2'b01, 8'hFF}, 8'h00, 1);
    repeat (4) step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule